// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a 32-bit processor core that completes one instruction per clock. In that clock the core fetches the instruction word at the program counter, decodes it, reads two source registers, and computes a result with an adder/logic unit. It then either writes a register, stores to data memory or redirects the program counter, and the effects take hold at the next rising edge. Both memories are small word-indexed arrays inside the core. Instruction memory is loaded from outside by hierarchical writes before reset is released. The instruction set covers register add, subtract, AND and OR, immediate add and immediate OR, word load and store, branch-if-equal, and a branch that links to register 31 when the tested register is negative. There are no delay slots.

The register-file write port, the data-memory write port and the program counter are all visible at the boundary. Any register value can therefore be observed, either when it is written or by storing it to memory.

Top module: `mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the next `pc_o` is 0. While `rst` is high, `rf_we_o` and `dm_we_o` stay low.
- R2: Fields sit at opcode [31:26], rs [25:21], rt [20:16], rd [15:11] and immediate [15:0]. Register ops use opcode 000000 with funct [5:0] 100001 add, 100011 subtract, 100100 AND and 100101 OR. Immediate add is 001001, immediate OR is 001101, load is 100011, store is 101011 and branch-if-equal is 000100. Branch-and-link-if-negative is opcode 000001 with rt 10000.
- R3: The register add, subtract, AND and OR ops write R[rd] with R[rs] op R[rt], taken modulo 2^32.
- R4: Immediate OR writes R[rt] with R[rs] OR the zero-extended immediate.
- R5: Immediate add writes R[rt] with R[rs] plus the sign-extended immediate.
- R6: A store drives `dm_we_o` high with `dm_addr_o` = R[rs] + sign-extended immediate and `dm_wdata_o` = R[rt]. It never writes a register.
- R7: A load writes R[rt] with the memory word at index (R[rs] + sign-extended immediate) >> 2.
- R8: Branch-if-equal writes no register. When R[rs] equals R[rt], the next PC is PC+4 + (sign-extended immediate << 2). Otherwise the next PC is PC+4.
- R9: The instruction after a taken branch is not executed. The next instruction observed is the one at the target.
- R10: Branch-and-link-if-negative with R[rs] bit 31 set writes PC+4 into register 31 and branches as in R8. Otherwise it writes nothing and the next PC is PC+4.
- R11: Register 0 reads as zero. A write to it is dropped, and `rf_we_o` stays low for it.
- R12: Every instruction that does not take a branch advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Program counter of the instruction in execution |
| rf_we_o | output | 1 | Register write taking effect at the coming edge |
| rf_waddr_o | output | 5 | Destination register of that write |
| rf_wdata_o | output | 32 | Value being written |
| dm_we_o | output | 1 | Data-memory store taking effect at the coming edge |
| dm_addr_o | output | 32 | Byte address of the load or store |
| dm_wdata_o | output | 32 | Store data |

## Verification
The register write port and the store port are combinational from the instruction at `pc_o`, so their values are due in the same cycle that the instruction is fetched. The written register becomes readable by the instruction after it. `pc_o` holds the next address one rising edge later. For that reason a taken branch is confirmed by the PC of the following cycle, and a skipped instruction is confirmed because its write never appears. The bench releases reset and changes stimulus only at falling edges. It samples each cycle just after a falling edge, when that cycle's instruction has settled and before the edge that commits it.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN     = 32;
  localparam int NREG     = 32;
  localparam int RAW      = $clog2(NREG);
  localparam int LINK_REG = NREG - 1;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_EQ, NPC_LTZ} npc_e;

  typedef struct packed {
    logic    ext_sign;
    logic    alu_imm;
    alu_op_e alu_op;
    logic    mem_wr;
    logic    mem_to_reg;
    logic    pc_to_reg;
    dst_e    reg_dst;
    logic    reg_wr;
    npc_e    npc_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{ext_sign: 1'b0, alu_imm: 1'b0, alu_op: ALU_ADD,
                                 mem_wr: 1'b0, mem_to_reg: 1'b0, pc_to_reg: 1'b0,
                                 reg_dst: DST_RT, reg_wr: 1'b0, npc_sel: NPC_SEQ};

  localparam logic [5:0] OP_REG    = 6'b000000;
  localparam logic [5:0] OP_REGIMM = 6'b000001;
  localparam logic [5:0] OP_BEQ    = 6'b000100;
  localparam logic [5:0] OP_ADDIU  = 6'b001001;
  localparam logic [5:0] OP_ORI    = 6'b001101;
  localparam logic [5:0] OP_LW     = 6'b100011;
  localparam logic [5:0] OP_SW     = 6'b101011;

  localparam logic [5:0] FN_ADDU   = 6'b100001;
  localparam logic [5:0] FN_SUBU   = 6'b100011;
  localparam logic [5:0] FN_AND    = 6'b100100;
  localparam logic [5:0] FN_OR     = 6'b100101;

  localparam logic [4:0] RT_LINKNEG = 5'b10000;

  function automatic logic [XLEN-1:0] alu_f(alu_op_e op, logic [XLEN-1:0] a,
                                            logic [XLEN-1:0] b);
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      default: return '0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] ext_f(logic [15:0] imm, logic sgn);
    return sgn ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] br_target_f(logic [XLEN-1:0] pc4,
                                                  logic [15:0] imm);
    return pc4 + {{(XLEN-18){imm[15]}}, imm, 2'b00};
  endfunction

endpackage

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] rt_field,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = CTRL_NOP;
    case (opcode)
      OP_REG: begin
        ctrl.reg_dst = DST_RD;
        ctrl.reg_wr  = 1'b1;
        case (funct)
          FN_ADDU: ctrl.alu_op = ALU_ADD;
          FN_SUBU: ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          default: ctrl.reg_wr = 1'b0;
        endcase
      end
      OP_ADDIU: begin
        ctrl.ext_sign = 1'b1;
        ctrl.alu_imm  = 1'b1;
        ctrl.alu_op   = ALU_ADD;
        ctrl.reg_dst  = DST_RT;
        ctrl.reg_wr   = 1'b1;
      end
      OP_ORI: begin
        ctrl.ext_sign = 1'b0;
        ctrl.alu_imm  = 1'b1;
        ctrl.alu_op   = ALU_OR;
        ctrl.reg_dst  = DST_RT;
        ctrl.reg_wr   = 1'b1;
      end
      OP_LW: begin
        ctrl.ext_sign   = 1'b1;
        ctrl.alu_imm    = 1'b1;
        ctrl.alu_op     = ALU_ADD;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_dst    = DST_RT;
        ctrl.reg_wr     = 1'b1;
      end
      OP_SW: begin
        ctrl.ext_sign = 1'b1;
        ctrl.alu_imm  = 1'b1;
        ctrl.alu_op   = ALU_ADD;
        ctrl.mem_wr   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.alu_op  = ALU_SUB;
        ctrl.npc_sel = NPC_EQ;
      end
      OP_REGIMM: begin
        if (rt_field == RT_LINKNEG) begin
          ctrl.pc_to_reg = 1'b1;
          ctrl.reg_dst   = DST_LINK;
          ctrl.reg_wr    = 1'b1;
          ctrl.npc_sel   = NPC_LTZ;
        end
      end
      default: ctrl = CTRL_NOP;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs_q[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            zero
);

  assign res  = alu_f(op, a, b);
  assign zero = (res == '0);

endmodule

// File: rtl/core_nextpc.sv
module core_nextpc
  import core_pkg::*;
(
  input  logic [XLEN-1:0] pc,
  input  logic [15:0]     imm,
  input  npc_e            sel,
  input  logic            equal,
  input  logic            negative,
  output logic [XLEN-1:0] pc_plus4,
  output logic [XLEN-1:0] pc_next,
  output logic            taken
);

  assign pc_plus4 = pc + XLEN'(4);

  always_comb begin
    case (sel)
      NPC_EQ:  taken = equal;
      NPC_LTZ: taken = negative;
      default: taken = 1'b0;
    endcase
  end

  assign pc_next = taken ? br_target_f(pc_plus4, imm) : pc_plus4;

endmodule

// File: rtl/mini_core.sv
module mini_core
  import core_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
  end

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] instr;
  logic [5:0]      f_op;
  logic [4:0]      rs_idx;
  logic [4:0]      rt_idx;
  logic [4:0]      rd_idx;
  logic [15:0]     f_imm;
  logic [5:0]      f_fn;
  logic            unused_shamt;

  assign instr        = imem_q[pc_q[IAW+1:2]];
  assign f_op         = instr[31:26];
  assign rs_idx       = instr[25:21];
  assign rt_idx       = instr[20:16];
  assign rd_idx       = instr[15:11];
  assign f_imm        = instr[15:0];
  assign f_fn         = instr[5:0];
  assign unused_shamt = ^instr[10:6];

  ctrl_t ctrl;

  core_ctrl u_ctrl (
    .opcode   (f_op),
    .funct    (f_fn),
    .rt_field (rt_idx),
    .ctrl     (ctrl)
  );

  logic [XLEN-1:0] rs_val;
  logic [XLEN-1:0] rt_val;
  logic            wr_en;
  logic [RAW-1:0]  wr_addr;
  logic [XLEN-1:0] wr_data;

  core_regfile #(.NREGS(NREG), .W(XLEN)) u_rf (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (wr_data),
    .raddr_a (rs_idx),
    .rdata_a (rs_val),
    .raddr_b (rt_idx),
    .rdata_b (rt_val)
  );

  logic [XLEN-1:0] imm_ext;
  logic [XLEN-1:0] alu_b;
  logic [XLEN-1:0] alu_res;
  logic            alu_zero;

  assign imm_ext = ext_f(f_imm, ctrl.ext_sign);
  assign alu_b   = ctrl.alu_imm ? imm_ext : rt_val;

  core_alu u_alu (
    .op   (ctrl.alu_op),
    .a    (rs_val),
    .b    (alu_b),
    .res  (alu_res),
    .zero (alu_zero)
  );

  logic            rs_negative;
  logic [XLEN-1:0] pc_plus4;
  logic [XLEN-1:0] pc_next;
  logic            br_taken;

  assign rs_negative = rs_val[XLEN-1];

  core_nextpc u_npc (
    .pc       (pc_q),
    .imm      (f_imm),
    .sel      (ctrl.npc_sel),
    .equal    (alu_zero),
    .negative (rs_negative),
    .pc_plus4 (pc_plus4),
    .pc_next  (pc_next),
    .taken    (br_taken)
  );

  // data memory: store commits at the edge, load is read combinationally
  logic [DAW-1:0]  dm_idx;
  logic [XLEN-1:0] dm_rdata;
  logic            store_en;

  assign dm_idx   = alu_res[DAW+1:2];
  assign dm_rdata = dmem_q[dm_idx];
  assign store_en = !rst && ctrl.mem_wr;

  always_ff @(posedge clk) begin
    if (store_en) dmem_q[dm_idx] <= rt_val;
  end

  // write-back selection
  always_comb begin
    case (ctrl.reg_dst)
      DST_RD:   wr_addr = rd_idx;
      DST_LINK: wr_addr = RAW'(LINK_REG);
      default:  wr_addr = rt_idx;
    endcase
  end

  always_comb begin
    if (ctrl.pc_to_reg)       wr_data = pc_plus4;
    else if (ctrl.mem_to_reg) wr_data = dm_rdata;
    else                      wr_data = alu_res;
  end

  logic link_cond;
  logic link_wr;

  assign link_cond = !ctrl.pc_to_reg || rs_negative;
  assign wr_en     = !rst && ctrl.reg_wr && link_cond && (wr_addr != '0);
  assign link_wr   = wr_en && ctrl.pc_to_reg;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc_o       = pc_q;
  assign rf_we_o    = wr_en;
  assign rf_waddr_o = wr_addr;
  assign rf_wdata_o = wr_data;
  assign dm_we_o    = store_en;
  assign dm_addr_o  = alu_res;
  assign dm_wdata_o = rt_val;

endmodule

// File: rtl/core_chk.sv
module core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        rf_we,
  input logic [4:0]  rf_waddr,
  input logic [31:0] rf_wdata,
  input logic        dm_we,
  input logic        taken,
  input logic        link,
  input logic [4:0]  rs_addr,
  input logic [31:0] rs_data
);

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  assert_quiet_reset_R1: assert property (@(posedge clk) rst |-> (!rf_we && !dm_we));

  assert_seq_pc_R12: assert property (@(posedge clk) disable iff (rst)
    !taken |=> pc == $past(pc) + 32'd4);

  assert_store_no_wb_R6: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> !rf_we);

  assert_link_target_R10: assert property (@(posedge clk) disable iff (rst)
    link |-> (rf_we && rf_waddr == 5'd31 && rf_wdata == pc + 32'd4));

  assert_zero_reg_R11: assert property (@(posedge clk) disable iff (rst)
    (rs_addr == 5'd0) |-> (rs_data == 32'd0));

  assert_no_zero_write_R11: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr != 5'd0));

  assert_branch_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
    (taken && !link) |-> !rf_we);

endmodule

bind mini_core core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_o),
  .rf_we    (rf_we_o),
  .rf_waddr (rf_waddr_o),
  .rf_wdata (rf_wdata_o),
  .dm_we    (dm_we_o),
  .taken    (br_taken),
  .link     (link_wr),
  .rs_addr  (rs_idx),
  .rs_data  (rs_val)
);

// File: tb/mini_core_test.sv
module mini_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_o;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        dm_we_o;
  logic [31:0] dm_addr_o;
  logic [31:0] dm_wdata_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  mini_core uut (
    .clk        (clk),
    .rst        (rst),
    .pc_o       (pc_o),
    .rf_we_o    (rf_we_o),
    .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o),
    .dm_we_o    (dm_we_o),
    .dm_addr_o  (dm_addr_o),
    .dm_wdata_o (dm_wdata_o)
  );

  // instruction builders (R2 field layout)
  function automatic logic [31:0] op_r(logic [5:0] fn, int rs, int rt, int rd);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
  endfunction
  function automatic logic [31:0] op_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] op_bl(int rs, int imm);
    return {6'b000001, 5'(rs), 5'b10000, 16'(imm)};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) uut.imem_q[i] = 32'd0;
  endtask

  task automatic start();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  // register write expected this cycle
  task automatic exp_wr(string req, logic [31:0] pc, int rd, logic [31:0] val);
    chk(req, "pc", pc_o, pc);
    chk(req, "rf_we", 32'(rf_we_o), 32'd1);
    chk(req, "rf_waddr", 32'(rf_waddr_o), 32'(rd));
    chk(req, "rf_wdata", rf_wdata_o, val);
    chk(req, "dm_we", 32'(dm_we_o), 32'd0);
  endtask

  // no register write, no store
  task automatic exp_none(string req, logic [31:0] pc);
    chk(req, "pc", pc_o, pc);
    chk(req, "rf_we", 32'(rf_we_o), 32'd0);
    chk(req, "dm_we", 32'(dm_we_o), 32'd0);
  endtask

  task automatic exp_st(string req, logic [31:0] pc, logic [31:0] addr, logic [31:0] val);
    chk(req, "pc", pc_o, pc);
    chk(req, "dm_we", 32'(dm_we_o), 32'd1);
    chk(req, "dm_addr", dm_addr_o, addr);
    chk(req, "dm_wdata", dm_wdata_o, val);
    chk(req, "rf_we", 32'(rf_we_o), 32'd0);
  endtask

  task automatic t_reset();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 1, 5);
    uut.imem_q[1] = op_i(6'b101011, 0, 1, 0);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1: PC held at 0, write ports quiet while reset is high
    exp_none("R1", 32'd0);
    @(negedge clk);
    #1;
    exp_none("R1", 32'd0);
  endtask

  task automatic t_regops();
    logic [31:0] a = 32'h0000_7fff;
    logic [31:0] b = 32'hffff_fffd;
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 1, 16'h7fff);
    uut.imem_q[1] = op_i(6'b001001, 0, 2, -3);
    uut.imem_q[2] = op_r(6'b100001, 1, 2, 3);
    uut.imem_q[3] = op_r(6'b100011, 1, 2, 4);
    uut.imem_q[4] = op_r(6'b100100, 1, 2, 5);
    uut.imem_q[5] = op_r(6'b100101, 1, 2, 6);
    uut.imem_q[6] = op_r(6'b100011, 0, 1, 7);
    start();
    exp_wr("R5", 32'd0, 1, a);
    nxt(); exp_wr("R5", 32'd4, 2, b);
    nxt(); exp_wr("R3", 32'd8, 3, a + b);
    nxt(); exp_wr("R3", 32'd12, 4, a - b);
    nxt(); exp_wr("R3", 32'd16, 5, a & b);
    nxt(); exp_wr("R3", 32'd20, 6, a | b);
    nxt(); exp_wr("R3", 32'd24, 7, 32'd0 - a);
    nxt(); exp_none("R12", 32'd28);
  endtask

  task automatic t_ori();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001101, 0, 2, 16'h8001);
    uut.imem_q[1] = op_i(6'b001101, 2, 3, 16'h00f0);
    start();
    exp_wr("R4", 32'd0, 2, 32'h0000_8001);
    nxt(); exp_wr("R4", 32'd4, 3, 32'h0000_80f1);
  endtask

  task automatic t_mem();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 1, 16);
    uut.imem_q[1] = op_i(6'b001001, 0, 2, 16'h1234);
    uut.imem_q[2] = op_i(6'b001001, 0, 3, -7);
    uut.imem_q[3] = op_i(6'b101011, 1, 2, 8);
    uut.imem_q[4] = op_i(6'b101011, 1, 3, -4);
    uut.imem_q[5] = op_i(6'b100011, 1, 4, 8);
    uut.imem_q[6] = op_i(6'b100011, 1, 5, -4);
    start();
    exp_wr("R5", 32'd0, 1, 32'd16);
    nxt(); exp_wr("R5", 32'd4, 2, 32'h1234);
    nxt(); exp_wr("R5", 32'd8, 3, 32'hffff_fff9);
    nxt(); exp_st("R6", 32'd12, 32'd24, 32'h1234);
    nxt(); exp_st("R6", 32'd16, 32'd12, 32'hffff_fff9);
    nxt(); exp_wr("R7", 32'd20, 4, 32'h1234);
    nxt(); exp_wr("R7", 32'd24, 5, 32'hffff_fff9);
  endtask

  task automatic t_beq();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 1, 5);
    uut.imem_q[1] = op_i(6'b001001, 0, 2, 5);
    uut.imem_q[2] = op_i(6'b000100, 1, 2, 2);
    uut.imem_q[3] = op_i(6'b001001, 0, 9, 1);
    uut.imem_q[4] = op_i(6'b001001, 0, 9, 2);
    uut.imem_q[5] = op_i(6'b001001, 0, 3, 7);
    uut.imem_q[6] = op_i(6'b000100, 1, 3, 5);
    uut.imem_q[7] = op_i(6'b000100, 0, 0, -8);
    start();
    exp_wr("R5", 32'd0, 1, 32'd5);
    nxt(); exp_wr("R5", 32'd4, 2, 32'd5);
    nxt(); exp_none("R8", 32'd8);
    // R9: target 8+4+8 = 20, instruction at 12 skipped
    nxt(); exp_wr("R9", 32'd20, 3, 32'd7);
    nxt(); exp_none("R8", 32'd24);
    nxt(); exp_none("R8", 32'd28);
    // backward branch: 28+4-32 = 0
    nxt(); exp_wr("R8", 32'd0, 1, 32'd5);
  endtask

  task automatic t_link();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 1, -1);
    uut.imem_q[1] = op_bl(1, 3);
    uut.imem_q[2] = op_i(6'b001001, 0, 9, 1);
    uut.imem_q[5] = op_i(6'b001001, 0, 2, 1);
    uut.imem_q[6] = op_bl(2, 4);
    uut.imem_q[7] = op_bl(0, 4);
    uut.imem_q[8] = op_i(6'b101011, 0, 31, 0);
    start();
    exp_wr("R5", 32'd0, 1, 32'hffff_ffff);
    nxt(); exp_wr("R10", 32'd4, 31, 32'd8);
    nxt(); exp_wr("R9", 32'd20, 2, 32'd1);
    nxt(); exp_none("R10", 32'd24);
    nxt(); exp_none("R10", 32'd28);
    nxt(); exp_st("R10", 32'd32, 32'd0, 32'd8);
  endtask

  task automatic t_zero();
    clear_prog();
    uut.imem_q[0] = op_i(6'b001001, 0, 0, 9);
    uut.imem_q[1] = op_r(6'b100001, 0, 0, 1);
    uut.imem_q[2] = op_i(6'b101011, 0, 0, 4);
    start();
    exp_none("R11", 32'd0);
    nxt(); exp_wr("R11", 32'd4, 1, 32'd0);
    nxt(); exp_st("R11", 32'd8, 32'd4, 32'd0);
    nxt(); exp_none("R12", 32'd12);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regops();
    t_ori();
    t_mem();
    t_beq();
    t_link();
    t_zero();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule